// File: doc/BRIEF.md
# Translation Cache with Global-Entry Flush Control

This block is a small, fully associative cache of virtual-to-physical page translations for a 32-bit, two-level paging scheme with 4 KiB pages. Each of its entries keeps a virtual page number, a frame number, a writable bit, a user bit and a global flag. A combinational lookup port reports hit or miss for a 20-bit virtual page number. On a hit it also returns the frame and the permission bits in the same cycle.

After a miss, an external table walker writes the result back through a fill port. The walker supplies the virtual page number, the directory entry and the leaf table entry. The cache never stores a translation whose directory or leaf entry is not present. Because of this, a page that has just been mapped is always looked up again in the tables.

Two commands remove entries. A table-base write drops every entry, but when global pages are enabled it keeps the entries flagged global. A single-page invalidate drops the one entry for a given virtual page, whether or not that entry is global.

Top module: `xlat_cache`

## Requirements
- R1: While reset is asserted, and after it is released, every entry is invalid and every lookup misses.
- R2: Lookup is combinational. When a valid entry matches the page number, hit is 1 in the same cycle and the frame and permissions come from that entry. Otherwise hit is 0.
- R3: A fill is stored only if bit 0 (present) is set in both the directory entry and the leaf entry. Otherwise the fill is dropped and a later lookup of that page misses.
- R4: A stored frame equals leaf bits 31:12. Writable equals directory bit 1 AND leaf bit 1. User equals directory bit 2 AND leaf bit 2.
- R5: When the global-enable input is 1, a table-base write invalidates every entry except those stored with the global flag set. The global flag is taken from leaf bit 8.
- R6: When the global-enable input is 0, a table-base write invalidates every entry, global or not.
- R7: Bit 8 of the directory entry has no effect. An entry with directory bit 8 set and leaf bit 8 clear is not global.
- R8: A page invalidate removes only the entry that matches its virtual page number, even when that entry is global. All other entries keep hitting.
- R9: A fill for a page that is already cached overwrites that same entry. No second copy is made, and lookups return the new contents.
- R10: A new page goes into the lowest-numbered invalid entry. When every entry is valid, it goes into the entry chosen by a round-robin pointer. The pointer is 0 after reset and moves up by one (wrapping) on each such replacement.
- R11: Commands take effect at the next clock edge. When an invalidate command and a fill arrive in the same cycle, the invalidate is applied first and the fill second, so the filled page hits afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global-page enable; when 1, global entries survive a table-base write |
| lk_vpn_i | input | 20 | Lookup virtual page number |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pfn_o | output | 20 | Frame number on hit, zero on miss |
| lk_wr_o | output | 1 | Writable permission on hit |
| lk_usr_o | output | 1 | User permission on hit |
| fill_i | input | 1 | Fill strobe from the walker |
| fill_vpn_i | input | 20 | Virtual page number being filled |
| fill_pde_i | input | 32 | Directory entry that the walk used |
| fill_pte_i | input | 32 | Leaf entry that the walk read |
| base_wr_i | input | 1 | Table-base write strobe (flush) |
| inv_pg_i | input | 1 | Single-page invalidate strobe |
| inv_vpn_i | input | 20 | Virtual page number to invalidate |

## Verification
The bench targets five corner cases.

- **Global survival and its enable.** A design that ignored the enable would leave stale global pages after a full flush. A design that took the flag from the directory entry would keep pages that should have been dropped.
- **Global entry hit by a page invalidate.** A design that spared global entries on a page invalidate would keep serving a translation that was removed.
- **Same-cycle invalidate and fill.** A design that applied the fill first would lose the newly filled page.
- **Overwrite in place.** A design that filled a second slot would hold duplicate matches, and its lookup would return a mixed frame.
- **Free slot before round-robin.** A design that always used the round-robin pointer would evict a live page while a freed slot sat empty.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W = 20;
  localparam int PFN_W = 20;
  localparam int PTE_W = 32;
  localparam int BIT_P = 0;
  localparam int BIT_W = 1;
  localparam int BIT_U = 2;
  localparam int BIT_G = 8;
  localparam int PFN_LSB = PTE_W - PFN_W;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    logic             wr;
    logic             usr;
    logic             glb;
  } xlat_ent_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N = 16,
  parameter int W = 20
) (
  input  logic [N-1:0]        valid_i,
  input  logic [N-1:0][W-1:0] tag_i,
  input  logic [W-1:0]        key_i,
  output logic [N-1:0]        hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_o[i] = valid_i[i] && (tag_i[i] == key_i);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  free_i,
  input  logic          repl_i,
  output logic [IW-1:0] idx_o,
  output logic          any_free_o
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;

  // lowest free slot wins
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) free_idx = IW'(i);
    end
  end

  assign any_free_o = |free_i;
  assign idx_o      = any_free_o ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (repl_i) begin
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int N = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [PFN_W-1:0] lk_pfn_o,
  output logic             lk_wr_o,
  output logic             lk_usr_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PTE_W-1:0] fill_pde_i,
  input  logic [PTE_W-1:0] fill_pte_i,
  input  logic             base_wr_i,
  input  logic             inv_pg_i,
  input  logic [VPN_W-1:0] inv_vpn_i
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  xlat_ent_t               ent_q [N];
  logic [N-1:0]            valid_q;
  logic [N-1:0]            glob_q;
  logic [N-1:0][VPN_W-1:0] vpn_tags;

  logic [N-1:0] lk_vec, inv_vec, fill_vec;
  logic [N-1:0] keep_vec, valid_inv, wr_sel;
  logic [IDX_W-1:0] victim_idx;
  logic any_free, fill_ok, fill_hit, repl;
  xlat_ent_t new_ent;

  logic unused_pte_bits;
  assign unused_pte_bits = ^{fill_pte_i[BIT_G-1:BIT_U+1], fill_pte_i[PFN_LSB-1:BIT_G+1],
                             fill_pde_i[PTE_W-1:BIT_U+1]};

  for (genvar i = 0; i < N; i++) begin : g_view
    assign vpn_tags[i] = ent_q[i].vpn;
    assign glob_q[i]   = ent_q[i].glb;
    // flush keeps global entries only while enabled
    assign keep_vec[i] = !base_wr_i || (glb_en_i && ent_q[i].glb);
  end

  xlat_match #(.N(N), .W(VPN_W)) u_lk_match (
    .valid_i(valid_q), .tag_i(vpn_tags), .key_i(lk_vpn_i), .hit_o(lk_vec)
  );

  xlat_match #(.N(N), .W(VPN_W)) u_inv_match (
    .valid_i(valid_q), .tag_i(vpn_tags), .key_i(inv_vpn_i), .hit_o(inv_vec)
  );

  assign valid_inv = valid_q & keep_vec & ~(inv_vec & {N{inv_pg_i}});

  // fill sees the post-invalidate state
  xlat_match #(.N(N), .W(VPN_W)) u_fill_match (
    .valid_i(valid_inv), .tag_i(vpn_tags), .key_i(fill_vpn_i), .hit_o(fill_vec)
  );

  assign fill_ok  = fill_i && fill_pde_i[BIT_P] && fill_pte_i[BIT_P];
  assign fill_hit = |fill_vec;
  assign repl     = fill_ok && !fill_hit && !any_free;

  xlat_victim #(.N(N), .IW(IDX_W)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .free_i(~valid_inv), .repl_i(repl),
    .idx_o(victim_idx), .any_free_o(any_free)
  );

  always_comb begin
    new_ent.vpn = fill_vpn_i;
    new_ent.pfn = fill_pte_i[PTE_W-1:PFN_LSB];
    new_ent.wr  = fill_pde_i[BIT_W] && fill_pte_i[BIT_W];
    new_ent.usr = fill_pde_i[BIT_U] && fill_pte_i[BIT_U];
    new_ent.glb = fill_pte_i[BIT_G];
  end

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign wr_sel[i] = fill_ok && (fill_hit ? fill_vec[i] : (victim_idx == IDX_W'(i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else begin
      valid_q <= valid_inv | wr_sel;
      for (int i = 0; i < N; i++) begin
        if (wr_sel[i]) ent_q[i] <= new_ent;
      end
    end
  end

  always_comb begin
    lk_pfn_o = '0;
    lk_wr_o  = 1'b0;
    lk_usr_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      lk_pfn_o = lk_pfn_o | (ent_q[i].pfn & {PFN_W{lk_vec[i]}});
      lk_wr_o  = lk_wr_o  | (ent_q[i].wr  & lk_vec[i]);
      lk_usr_o = lk_usr_o | (ent_q[i].usr & lk_vec[i]);
    end
  end

  assign lk_hit_o = |lk_vec;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int N = 16,
  parameter int VW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          glb_en_i,
  input logic          base_wr_i,
  input logic          inv_pg_i,
  input logic [VW-1:0] inv_vpn_i,
  input logic          fill_i,
  input logic [VW-1:0] lk_vpn_i,
  input logic          lk_hit_o,
  input logic [N-1:0]  valid_q,
  input logic [N-1:0]  glob_q,
  input logic [N-1:0]  lk_vec
);
  assert_clear_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> valid_q == '0);

  assert_single_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec));

  assert_keep_global_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_wr_i && glb_en_i && !fill_i && !inv_pg_i)
      |=> $countones(valid_q) == $past($countones(valid_q & glob_q)));

  assert_flush_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_wr_i && !glb_en_i && !fill_i) |=> valid_q == '0);

  assert_page_gone_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_pg_i && !fill_i) |=> (lk_vpn_i != $past(inv_vpn_i)) || !lk_hit_o);
endmodule

bind xlat_cache xlat_cache_chk #(.N(N), .VW(xlat_pkg::VPN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .base_wr_i(base_wr_i),
  .inv_pg_i(inv_pg_i), .inv_vpn_i(inv_vpn_i), .fill_i(fill_i), .lk_vpn_i(lk_vpn_i),
  .lk_hit_o(lk_hit_o), .valid_q(valid_q), .glob_q(glob_q), .lk_vec(lk_vec)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam logic [1:0] OP_LOOK = 2'd0, OP_FILL = 2'd1, OP_BASE = 2'd2, OP_INVP = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] vpn;
    logic [31:0] pte;
    logic        hit;
    logic [19:0] pfn;
    logic        wr;
    logic        usr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{OP_LOOK, 20'h00010, 32'h0,          1'b0, 20'h0,     1'b0, 1'b0, 8'd2},  // R2 cold miss
    '{OP_FILL, 20'h00010, 32'h12345003,   1'b0, 20'h0,     1'b0, 1'b0, 8'd3},
    '{OP_LOOK, 20'h00010, 32'h0,          1'b1, 20'h12345, 1'b1, 1'b0, 8'd2},  // R2
    '{OP_FILL, 20'h00020, 32'h0ABCD105,   1'b0, 20'h0,     1'b0, 1'b0, 8'd5},
    '{OP_LOOK, 20'h00020, 32'h0,          1'b1, 20'h0ABCD, 1'b0, 1'b1, 8'd4},  // R4
    '{OP_FILL, 20'h00030, 32'h00777002,   1'b0, 20'h0,     1'b0, 1'b0, 8'd3},
    '{OP_LOOK, 20'h00030, 32'h0,          1'b0, 20'h0,     1'b0, 1'b0, 8'd3},  // R3 not present
    '{OP_BASE, 20'h00000, 32'h0,          1'b0, 20'h0,     1'b0, 1'b0, 8'd5},
    '{OP_LOOK, 20'h00010, 32'h0,          1'b0, 20'h0,     1'b0, 1'b0, 8'd5},  // R5 flushed
    '{OP_LOOK, 20'h00020, 32'h0,          1'b1, 20'h0ABCD, 1'b0, 1'b1, 8'd5},  // R5 survives
    '{OP_FILL, 20'h00010, 32'h22222007,   1'b0, 20'h0,     1'b0, 1'b0, 8'd9},
    '{OP_LOOK, 20'h00010, 32'h0,          1'b1, 20'h22222, 1'b1, 1'b1, 8'd9},
    '{OP_FILL, 20'h00010, 32'h33333001,   1'b0, 20'h0,     1'b0, 1'b0, 8'd9},
    '{OP_LOOK, 20'h00010, 32'h0,          1'b1, 20'h33333, 1'b0, 1'b0, 8'd9},  // R9 overwrite
    '{OP_INVP, 20'h00020, 32'h0,          1'b0, 20'h0,     1'b0, 1'b0, 8'd8},
    '{OP_LOOK, 20'h00020, 32'h0,          1'b0, 20'h0,     1'b0, 1'b0, 8'd8},  // R8 global dropped
    '{OP_LOOK, 20'h00010, 32'h0,          1'b1, 20'h33333, 1'b0, 1'b0, 8'd8}   // R8 other kept
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, glb_en_i = 1'b0;
  logic [19:0] lk_vpn_i = '0, fill_vpn_i = '0, inv_vpn_i = '0;
  logic [31:0] fill_pde_i = '0, fill_pte_i = '0;
  logic fill_i = 1'b0, base_wr_i = 1'b0, inv_pg_i = 1'b0;
  logic lk_hit_o, lk_wr_o, lk_usr_o;
  logic [19:0] lk_pfn_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  xlat_cache u_xlat_cache (
    .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .lk_vpn_i(lk_vpn_i),
    .lk_hit_o(lk_hit_o), .lk_pfn_o(lk_pfn_o), .lk_wr_o(lk_wr_o), .lk_usr_o(lk_usr_o),
    .fill_i(fill_i), .fill_vpn_i(fill_vpn_i), .fill_pde_i(fill_pde_i), .fill_pte_i(fill_pte_i),
    .base_wr_i(base_wr_i), .inv_pg_i(inv_pg_i), .inv_vpn_i(inv_vpn_i)
  );

  task automatic look(input int req, input logic [19:0] vpn, input logic hit,
                      input logic [19:0] pfn, input logic wr, input logic usr);
    logic ok;
    lk_vpn_i = vpn;
    #1;
    checks++;
    ok = (lk_hit_o === hit) && (!hit || (lk_pfn_o === pfn && lk_wr_o === wr && lk_usr_o === usr));
    if (!ok) begin
      errors++;
      $display("FAIL R%0d vpn=%h actual hit=%b pfn=%h wr=%b usr=%b expected hit=%b pfn=%h wr=%b usr=%b",
               req, vpn, lk_hit_o, lk_pfn_o, lk_wr_o, lk_usr_o, hit, pfn, wr, usr);
    end
  endtask

  task automatic step(input logic f, input logic [19:0] fv, input logic [31:0] pde,
                      input logic [31:0] pte, input logic b, input logic iv, input logic [19:0] ivpn);
    @(negedge clk_i);
    fill_i = f; fill_vpn_i = fv; fill_pde_i = pde; fill_pte_i = pte;
    base_wr_i = b; inv_pg_i = iv; inv_vpn_i = ivpn;
    @(negedge clk_i);
    fill_i = 1'b0; base_wr_i = 1'b0; inv_pg_i = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [31:0] pde, input logic [31:0] pte);
    step(1'b1, v, pde, pte, 1'b0, 1'b0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    look(1, 20'h00010, 1'b0, '0, 1'b0, 1'b0);  // R1 during reset
    rst_ni = 1'b1;
    glb_en_i = 1'b1;
    look(1, 20'h00000, 1'b0, '0, 1'b0, 1'b0);  // R1 after release

    for (int k = 0; k < NV; k++) begin
      case (VECS[k].op)
        OP_LOOK: look(int'(VECS[k].req), VECS[k].vpn, VECS[k].hit, VECS[k].pfn, VECS[k].wr, VECS[k].usr);
        OP_FILL: fill(VECS[k].vpn, 32'h00000007, VECS[k].pte);
        OP_BASE: step(1'b0, '0, '0, '0, 1'b1, 1'b0, '0);
        default: step(1'b0, '0, '0, '0, 1'b0, 1'b1, VECS[k].vpn);
      endcase
    end

    // R6: flush with global disabled
    glb_en_i = 1'b0;
    fill(20'h00040, 32'h007, 32'h44444107);
    look(6, 20'h00040, 1'b1, 20'h44444, 1'b1, 1'b1);
    step(1'b0, '0, '0, '0, 1'b1, 1'b0, '0);
    look(6, 20'h00040, 1'b0, '0, 1'b0, 1'b0);
    glb_en_i = 1'b1;

    // R7: directory global bit ignored
    fill(20'h00050, 32'h107, 32'h55555003);
    fill(20'h00051, 32'h107, 32'h56565103);
    step(1'b0, '0, '0, '0, 1'b1, 1'b0, '0);
    look(7, 20'h00050, 1'b0, '0, 1'b0, 1'b0);
    look(5, 20'h00051, 1'b1, 20'h56565, 1'b1, 1'b0);

    // R4: permissions combine directory and leaf
    fill(20'h00060, 32'h005, 32'h66666007);
    look(4, 20'h00060, 1'b1, 20'h66666, 1'b0, 1'b1);
    fill(20'h00062, 32'h003, 32'h67676007);
    look(4, 20'h00062, 1'b1, 20'h67676, 1'b1, 1'b0);
    // R3: directory not present
    fill(20'h00061, 32'h006, 32'h61616007);
    look(3, 20'h00061, 1'b0, '0, 1'b0, 1'b0);

    // R11: same-cycle flush + fill, then same-cycle invalidate + fill
    step(1'b1, 20'h00070, 32'h007, 32'h70707003, 1'b1, 1'b0, '0);
    look(11, 20'h00070, 1'b1, 20'h70707, 1'b1, 1'b0);
    look(5, 20'h00060, 1'b0, '0, 1'b0, 1'b0);
    step(1'b1, 20'h00070, 32'h007, 32'h71717005, 1'b0, 1'b1, 20'h00070);
    look(11, 20'h00070, 1'b1, 20'h71717, 1'b0, 1'b1);
    look(8, 20'h00051, 1'b1, 20'h56565, 1'b1, 1'b0);

    // R1: reset mid-run
    do_reset();
    look(1, 20'h00051, 1'b0, '0, 1'b0, 1'b0);
    look(1, 20'h00070, 1'b0, '0, 1'b0, 1'b0);

    // R10: fill order and round-robin replacement
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 32'h007, {20'h00500 + 20'(i), 12'h003});
    for (int i = 0; i < 16; i++) look(10, 20'h00100 + 20'(i), 1'b1, 20'h00500 + 20'(i), 1'b1, 1'b0);
    fill(20'h00110, 32'h007, 32'h00510003);
    look(10, 20'h00100, 1'b0, '0, 1'b0, 1'b0);
    look(10, 20'h00110, 1'b1, 20'h00510, 1'b1, 1'b0);
    look(10, 20'h00101, 1'b1, 20'h00501, 1'b1, 1'b0);
    step(1'b0, '0, '0, '0, 1'b0, 1'b1, 20'h00105);
    fill(20'h00111, 32'h007, 32'h00511003);
    look(10, 20'h00101, 1'b1, 20'h00501, 1'b1, 1'b0);
    look(10, 20'h00111, 1'b1, 20'h00511, 1'b1, 1'b0);
    fill(20'h00112, 32'h007, 32'h00512003);
    look(10, 20'h00101, 1'b0, '0, 1'b0, 1'b0);
    look(10, 20'h00102, 1'b1, 20'h00502, 1'b1, 1'b0);
    look(10, 20'h00112, 1'b1, 20'h00512, 1'b1, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule